// File: doc/BRIEF.md
# Single-Chain Pointer-Chase Prefetcher

This block sits between a data cache and main memory and speeds up the walk along a linked list. The cache tags each read with a chase flag. A read with the flag set is taken to fetch a node whose contents hold the address of the next node. The block answers the read from a four-entry node buffer if it can, and from memory if it cannot. It then takes the next-node pointer from a fixed word of the returned node and queues a fetch of that node into the buffer. The next chase read along the list can then be answered without a trip to memory. Reads without the flag go straight to memory. They are answered but start no fetch.

Addresses name whole nodes. A node is `NODE_WORDS` words of `DW` bits each, and a pointer word is itself a node address. The buffer is direct-indexed by the low address bits. A pending-fetch queue drops pointers it already holds and pointers the buffer already holds. The block handles one cache request at a time. A request to memory is offered with a valid/ready handshake, and only one memory request is outstanding at any time.

Top module: `chase_prefetcher`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_req_valid_o` are 0.
- R2: A read with `req_chase_i`=0 is sent to memory at its own address. Its response carries the memory line, and no further memory request follows it.
- R3: A chase read that misses the buffer is sent to memory and answered with the memory line. Afterwards one memory request is issued to the next-node pointer taken from that line.
- R4: A chase read that hits the buffer is answered with the buffered line and issues no memory request for its own address. Only the fetch of the next pointer taken from that line follows.
- R5: The next pointer is word `ptr_off_i` of the line, where word k occupies bits [k*DW +: DW].
- R6: A next pointer equal to zero causes no memory request.
- R7: A next pointer that is already held in the buffer, or already waiting in the fetch queue, causes no new memory request.
- R8: When a cache request is waiting and a queued fetch is pending at the same moment, the cache request goes to memory first.
- R9: The buffer slot of a node is address bits [1:0]. Filling a slot replaces its previous node, and a later chase read of the replaced node goes to memory.
- R10: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request stays valid and `mem_req_addr_o` does not change.
- R11: From acceptance until its response, a cache request holds `req_ready_o` at 0. Each response is a single-cycle `rsp_valid_o` pulse, and each request gets exactly one response, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Cache read request valid |
| req_ready_o | output | 1 | Block can take a cache request |
| req_addr_i | input | DW | Node address of the read |
| req_chase_i | input | 1 | Read is a pointer-chase load |
| rsp_valid_o | output | 1 | Response pulse to the cache |
| rsp_data_o | output | NODE_WORDS*DW | Node line returned to the cache |
| ptr_off_i | input | $clog2(NODE_WORDS) | Word index of the next pointer in a node |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | DW | Node address sent to memory |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_data_i | input | NODE_WORDS*DW | Node line from memory |

## Verification
Two things can happen in the same cycle: a new cache request is waiting, and a pointer taken from the previous response is waiting in the fetch queue. The bench provokes this by presenting a second read at once after a chase read. The read stays valid while the block is busy, so it is still there when the block returns to idle with a fetch queued. The order of addresses in the bench's memory log decides the outcome: the second read must appear before the fetch. When the second read is a repeat chase of the same node, the log must show that the queued pointer was not requested a second time.

// File: rtl/pfc_pkg.sv
`timescale 1ns/1ps
package pfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MEM_WAIT,
    ST_RESPOND,
    ST_ISSUE_PF
  } pfc_state_e;
endpackage

// File: rtl/pfc_buffer.sv
`timescale 1ns/1ps
module pfc_buffer #(
  parameter int DW      = 32,
  parameter int ENTRIES = 4,
  parameter int LW      = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rd_addr_i,
  output logic          rd_hit_o,
  output logic [LW-1:0] rd_data_o,
  input  logic [DW-1:0] probe_addr_i,
  output logic          probe_hit_o,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_addr_i,
  input  logic [LW-1:0] wr_data_i
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = DW - IW;

  logic [ENTRIES-1:0] vld_q;
  logic [TW-1:0]      tag_q [ENTRIES];
  logic [LW-1:0]      dat_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_addr_i[IW-1:0] == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else if (sel) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_addr_i[DW-1:IW];
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel) dat_q[g] <= wr_data_i;
    end
  end

  logic [IW-1:0] rd_idx, pr_idx;
  assign rd_idx      = rd_addr_i[IW-1:0];
  assign pr_idx      = probe_addr_i[IW-1:0];
  assign rd_hit_o    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_addr_i[DW-1:IW]);
  assign rd_data_o   = dat_q[rd_idx];
  assign probe_hit_o = vld_q[pr_idx] && (tag_q[pr_idx] == probe_addr_i[DW-1:IW]);
endmodule

// File: rtl/pfc_queue.sv
`timescale 1ns/1ps
module pfc_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  input  logic [DW-1:0] probe_addr_i,
  output logic          probe_has_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_addr_i;
  end

  logic [DEPTH-1:0] match;
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [PW-1:0] age;
    assign age      = PW'(g) - rd_q;
    assign match[g] = (CW'(age) < cnt_q) && (mem_q[g] == probe_addr_i);
  end
  assign probe_has_o = |match;
endmodule

// File: rtl/pfc_ptr_pick.sv
`timescale 1ns/1ps
module pfc_ptr_pick #(
  parameter int DW = 32,
  parameter int NW = 4,
  parameter int OW = $clog2(NW)
) (
  input  logic [NW*DW-1:0] line_i,
  input  logic [OW-1:0]    off_i,
  output logic [DW-1:0]    ptr_o
);
  always_comb begin
    ptr_o = '0;
    for (int k = 0; k < NW; k++) begin
      if (off_i == OW'(k)) ptr_o = line_i[k*DW +: DW];
    end
  end
endmodule

// File: rtl/chase_prefetcher.sv
`timescale 1ns/1ps
module chase_prefetcher
  import pfc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NODE_WORDS = 4,
  parameter int ENTRIES    = 4,
  parameter int QDEPTH     = 4,
  localparam int LW        = NODE_WORDS * DW,
  localparam int OW        = $clog2(NODE_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [DW-1:0] req_addr_i,
  input  logic          req_chase_i,
  output logic          rsp_valid_o,
  output logic [LW-1:0] rsp_data_o,
  input  logic [OW-1:0] ptr_off_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [DW-1:0] mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [LW-1:0] mem_rsp_data_i
);
  pfc_state_e    state_q, state_d;
  logic [DW-1:0] req_addr_q;
  logic          req_chase_q;
  logic [LW-1:0] rsp_data_q;
  logic          sent_q;

  logic          buf_hit, buf_probe_hit, buf_wr;
  logic [LW-1:0] buf_data;
  logic [DW-1:0] next_ptr, q_head;
  logic          q_empty, q_has, q_push;
  logic          mem_done;

  pfc_buffer #(.DW(DW), .ENTRIES(ENTRIES), .LW(LW)) u_buf (
    .clk_i, .rst_ni,
    .rd_addr_i   (req_addr_q),
    .rd_hit_o    (buf_hit),
    .rd_data_o   (buf_data),
    .probe_addr_i(next_ptr),
    .probe_hit_o (buf_probe_hit),
    .wr_en_i     (buf_wr),
    .wr_addr_i   (q_head),
    .wr_data_i   (mem_rsp_data_i)
  );

  pfc_queue #(.DW(DW), .DEPTH(QDEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i      (q_push),
    .push_addr_i (next_ptr),
    .pop_i       (buf_wr),
    .head_o      (q_head),
    .empty_o     (q_empty),
    .probe_addr_i(next_ptr),
    .probe_has_o (q_has)
  );

  pfc_ptr_pick #(.DW(DW), .NW(NODE_WORDS)) u_pick (
    .line_i(rsp_data_q),
    .off_i (ptr_off_i),
    .ptr_o (next_ptr)
  );

  assign mem_done = sent_q && mem_rsp_valid_i;
  assign buf_wr   = (state_q == ST_ISSUE_PF) && mem_done;
  // drop null, already buffered and already queued pointers
  assign q_push   = (state_q == ST_RESPOND) && req_chase_q && (next_ptr != '0)
                    && !buf_probe_hit && !q_has;

  assign req_ready_o     = (state_q == ST_IDLE);
  assign rsp_valid_o     = (state_q == ST_RESPOND);
  assign rsp_data_o      = rsp_data_q;
  assign mem_req_valid_o = (state_q inside {ST_MEM_WAIT, ST_ISSUE_PF}) && !sent_q;
  assign mem_req_addr_o  = (state_q == ST_ISSUE_PF) ? q_head : req_addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i)   state_d = ST_LOOKUP;
        else if (!q_empty) state_d = ST_ISSUE_PF;
      end
      ST_LOOKUP:   state_d = (req_chase_q && buf_hit) ? ST_RESPOND : ST_MEM_WAIT;
      ST_MEM_WAIT: if (mem_done) state_d = ST_RESPOND;
      ST_RESPOND:  state_d = ST_IDLE;
      ST_ISSUE_PF: if (mem_done) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      req_chase_q <= 1'b0;
      rsp_data_q  <= '0;
      sent_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        req_addr_q  <= req_addr_i;
        req_chase_q <= req_chase_i;
      end
      if (state_q == ST_LOOKUP && req_chase_q && buf_hit) rsp_data_q <= buf_data;
      if (state_q == ST_MEM_WAIT && mem_done)             rsp_data_q <= mem_rsp_data_i;
      if (state_q inside {ST_IDLE, ST_LOOKUP})            sent_q <= 1'b0;
      else if (mem_req_valid_o && mem_req_ready_i)        sent_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pfc_checker.sv
`timescale 1ns/1ps
module pfc_checker #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic [DW-1:0] mem_req_addr_o
);
  AST_MEM_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o); // R10
  AST_MEM_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> $stable(mem_req_addr_o)); // R10
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R11
  AST_ONE_REQ_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o); // R11
  AST_NO_RSP_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R11
endmodule

bind chase_prefetcher pfc_checker #(.DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o)
);

// File: tb/tb_chase_prefetcher.sv
`timescale 1ns/1ps
module tb_chase_prefetcher;
  localparam int DW  = 32;
  localparam int NW  = 4;
  localparam int LW  = NW * DW;
  localparam int OW  = $clog2(NW);
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [DW-1:0] req_addr = '0;
  logic          req_chase = 1'b0;
  logic          rsp_valid;
  logic [LW-1:0] rsp_data;
  logic [OW-1:0] ptr_off = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [DW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [LW-1:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  chase_prefetcher dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_chase_i(req_chase),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .ptr_off_i(ptr_off),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  int mem_poff = 0;
  logic [DW-1:0] mem_log [$];
  logic [LW-1:0] exp_q [$];
  string         tag_q [$];

  function automatic logic [DW-1:0] next_of(logic [DW-1:0] a);
    if (a[11:8] == 4'h1 || a[11:8] == 4'h2 || a[11:8] == 4'h4) return a + 1;
    return '0;
  endfunction

  function automatic logic [LW-1:0] mem_line(logic [DW-1:0] a);
    logic [LW-1:0] l;
    for (int w = 0; w < NW; w++)
      l[w*DW +: DW] = (w == mem_poff) ? next_of(a) : {4'hA, a[23:0], 4'(w)};
    return l;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: random ready, fixed latency, one outstanding
  initial begin
    bit busy = 0;
    int cnt = 0;
    logic [DW-1:0] pa = '0;
    logic [3:0] lfsr = 4'h9;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      if (busy) begin
        mem_req_ready = 1'b0;
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_line(pa);
          busy = 0;
        end
      end else begin
        mem_req_ready = lfsr[0] | lfsr[1];
        if (mem_req_ready && mem_req_valid && rst_n) begin
          busy = 1;
          cnt  = LAT;
          pa   = mem_req_addr;
          mem_log.push_back(mem_req_addr);
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected response", rsp_data, '0);
      end else begin
        logic [LW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_data === e, t, rsp_data, e);
      end
    end
  end

  task automatic send(input logic [DW-1:0] a, input bit chase, input string tag);
    exp_q.push_back(mem_line(a));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_chase = chase;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic chk_log(input int idx, input logic [DW-1:0] exp, input string tag);
    logic [DW-1:0] act;
    act = (idx < mem_log.size()) ? mem_log[idx] : 'x;
    chk(idx < mem_log.size() && act == exp, tag, LW'(act), LW'(exp));
  endtask

  task automatic chk_size(input int exp, input string tag);
    chk(mem_log.size() == exp, tag, LW'(mem_log.size()), LW'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", LW'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R1 no response in reset", LW'(rsp_valid), 0);
    chk(mem_req_valid === 1'b0, "R1 no mem request in reset", LW'(mem_req_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready === 1'b1 && mem_req_valid === 1'b0, "R1 idle after reset",
        LW'({req_ready, mem_req_valid}), LW'(2'b10));

    // R2 ordinary read
    b = mem_log.size();
    send(32'h150, 0, "R2 ordinary read data");
    settle();
    chk_size(b + 1, "R2 no prefetch after ordinary read");
    chk_log(b, 32'h150, "R2 ordinary read address");

    // R3 chase miss then prefetch of next
    b = mem_log.size();
    send(32'h100, 1, "R3 chase miss data");
    settle();
    chk_size(b + 2, "R3 demand plus one prefetch");
    chk_log(b, 32'h100, "R3 demand address");
    chk_log(b + 1, 32'h101, "R3 prefetch of word 0 pointer");

    // R4 chase hit
    b = mem_log.size();
    send(32'h101, 1, "R4 chase hit data");
    settle();
    chk_size(b + 1, "R4 only the next prefetch");
    chk_log(b, 32'h102, "R4 next pointer from buffered line");

    // R7 pointer already buffered
    b = mem_log.size();
    send(32'h100, 1, "R7 repeat chase data");
    settle();
    chk_size(b + 1, "R7 buffered pointer dropped");

    // R6 null pointer
    b = mem_log.size();
    send(32'h300, 1, "R6 null chase data");
    settle();
    chk_size(b + 1, "R6 no prefetch for null pointer");

    // R9 slot conflict: 0x105 replaces 0x101 in slot 1
    b = mem_log.size();
    send(32'h104, 1, "R9 fill slot 1 data");
    settle();
    chk_log(b + 1, 32'h105, "R9 prefetch to slot 1");
    b = mem_log.size();
    send(32'h101, 1, "R9 replaced node data");
    settle();
    chk_size(b + 1, "R9 R7 replaced node refetched, 0x102 still buffered");
    chk_log(b, 32'h101, "R9 replaced node goes to memory");

    // R8 demand before queued fetch, R7 pointer already queued
    b = mem_log.size();
    send(32'h110, 1, "R8 first chase data");
    send(32'h110, 1, "R8 second chase data");
    settle();
    chk_size(b + 3, "R7 queued pointer not requested twice");
    chk_log(b + 1, 32'h110, "R8 second demand before prefetch");
    chk_log(b + 2, 32'h111, "R8 prefetch issued last");

    b = mem_log.size();
    send(32'h400, 1, "R8 chase data");
    send(32'h450, 0, "R8 ordinary data");
    settle();
    chk_log(b, 32'h400, "R8 chase address first");
    chk_log(b + 1, 32'h450, "R8 ordinary read beats queued fetch");
    chk_log(b + 2, 32'h401, "R8 queued fetch after demand");

    // R5 pointer offset
    ptr_off  = 2'd2;
    mem_poff = 2;
    b = mem_log.size();
    send(32'h200, 1, "R5 chase data at offset 2");
    settle();
    chk_size(b + 2, "R5 one prefetch at offset 2");
    chk_log(b + 1, 32'h201, "R5 pointer from word 2");
    b = mem_log.size();
    send(32'h201, 1, "R5 hit data at offset 2");
    settle();
    chk_size(b + 1, "R5 R4 hit with offset 2");
    chk_log(b, 32'h202, "R5 next from buffered word 2");

    chk(exp_q.size() == 0, "R11 every request answered", LW'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule